// File: doc/BRIEF.md
# Four-Bit Multifunction ALU Slice

This block is a purely combinational slice of an arithmetic logic unit. It works on two 4-bit operands and produces a 4-bit result. A mode input chooses between two sets of functions, each selected by a 4-bit code. The logic set holds 16 bitwise functions of the operands, and the carry input plays no part in them. The arithmetic set holds 16 two's-complement functions, and a carry input adds one to the result. All data is active high, but both carries and the two lookahead outputs are active low. A wider word is built by chaining slices through the ripple carry, or by feeding the group propagate and generate outputs to an external lookahead unit.

Every arithmetic function has the form X + Y, plus one when `cin_n` is low. X depends only on `sel[1:0]`: 00 gives A, 01 gives A|B, 10 gives A|~B, 11 gives 4'hF. Y depends only on `sel[3:2]`: 00 gives 0, 01 gives A&~B, 10 gives A&B, 11 gives A. The codes, with the logic result first and the arithmetic result (for `cin_n` high) second:

- 0000: ~A / A; 0001: ~(A|B) / A|B; 0010: ~A&B / A|~B; 0011: 4'h0 / 4'hF (minus one)
- 0100: ~(A&B) / A+(A&~B); 0101: ~B / (A|B)+(A&~B); 0110: A^B / A-B-1; 0111: A&~B / (A&~B)-1
- 1000: ~A|B / A+(A&B); 1001: ~(A^B) / A+B; 1010: B / (A|~B)+(A&B); 1011: A&B / (A&B)-1
- 1100: 4'hF / A+A; 1101: A|~B / (A|B)+A; 1110: A|B / (A|~B)+A; 1111: A / A-1

Code 0110 with `mode` low is the subtract mode, which is used for comparisons.

Top module: `alu4_slice`

## Requirements
- R1: With `mode` high, `f` equals the logic function listed for `sel`. For example, 0110 gives A^B, 1001 gives ~(A^B), 1100 gives all ones, and 0011 gives all zeros.
- R2: With `mode` low and `cin_n` high, `f` equals the arithmetic function listed for `sel`, taken modulo 16. For example, 1001 gives A+B, 0110 gives A-B-1, and 0000 gives A.
- R3: With `mode` low and `cin_n` low, `f` equals the R2 result plus one, modulo 16.
- R4: With `mode` low, `cout_n` is low exactly when X + Y + (carry in) exceeds 15.
- R5: `prop_n` is low exactly when X equals 4'hF, that is, when every bit position propagates.
- R6: `gen_n` is low exactly when X + Y exceeds 15, whatever the carry input is.
- R7: In subtract mode with `cin_n` high, `eq` is high exactly when A equals B.
- R8: In subtract mode, with `cin_n` high, `cout_n` is low exactly when A > B. With `cin_n` low, `cout_n` is low exactly when A >= B.
- R9: Two slices in code 1001, with the low slice's `cout_n` wired to the high slice's `cin_n`, form a correct 8-bit adder.
- R10: With `mode` high, `cin_n` has no effect on `f`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| sel | input | 4 | Function code |
| mode | input | 1 | High selects logic, low selects arithmetic |
| cin_n | input | 1 | Carry input, active low |
| f | output | 4 | Result |
| cout_n | output | 1 | Ripple carry output, active low |
| prop_n | output | 1 | Group propagate, active low |
| gen_n | output | 1 | Group generate, active low |
| eq | output | 1 | Equality flag (AND of all result bits) |

## Verification
The checker evaluates its properties whenever the ports change. It therefore assumes that the inputs carry known 0/1 values and that the outputs are read once the slice has settled. The bench meets both conditions. It drives every input with a defined value at the same instant, and it waits half a clock period before comparing. It does this through an exhaustive sweep of operands, codes, mode and carry, followed by random and boundary additions on a two-slice cascade.

// File: rtl/alu4_slice.sv
module alu4_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  input  logic         mode,
  input  logic         cin_n,
  output logic [W-1:0] f,
  output logic         cout_n,
  output logic         prop_n,
  output logic         gen_n,
  output logic         eq
);

  logic [W-1:0] px, gx, half;
  logic [W:0]   cy;
  logic         grp_g;

  assign px   = a | (b & {W{sel[0]}}) | (~b & {W{sel[1]}});
  assign gx   = (a & ~b & {W{sel[2]}}) | (a & b & {W{sel[3]}});
  assign half = px ^ gx;

  always_comb begin
    cy[0] = ~cin_n;
    for (int i = 0; i < W; i++)
      cy[i+1] = gx[i] | (px[i] & cy[i]);
  end

  always_comb begin
    grp_g = 1'b0;
    for (int i = 0; i < W; i++)
      grp_g = gx[i] | (px[i] & grp_g);
  end

  assign f      = mode ? ~half : (half ^ cy[W-1:0]);
  assign cout_n = ~cy[W];
  assign prop_n = ~(&px);
  assign gen_n  = ~grp_g;
  assign eq     = &f;

endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   sel,
  input logic         mode,
  input logic         cin_n,
  input logic [W-1:0] f,
  input logic         cout_n,
  input logic         prop_n,
  input logic         gen_n,
  input logic         eq
);

  logic [W:0] add_full;
  assign add_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ~cin_n};

  always_comb begin
    if (!mode && sel == 4'b1001)
      p_add_sum_r2: assert ({~cout_n, f} == add_full) else $error("add mismatch");
    if (mode && sel == 4'b0110)
      p_logic_xor_r1: assert (f == (a ^ b)) else $error("xor mismatch");
    if (mode && sel == 4'b1100)
      p_logic_ones_r1: assert (&f) else $error("ones mismatch");
    if (!mode && sel == 4'b0110 && cin_n)
      p_equal_flag_r7: assert (eq == (a == b)) else $error("equality mismatch");
    if (!mode && sel == 4'b0110)
      p_magnitude_r8: assert ((!cout_n) == (cin_n ? (a > b) : (a >= b))) else $error("magnitude mismatch");
    if (!gen_n)
      p_gen_forces_carry_r6: assert (!cout_n) else $error("generate without carry");
    if (!prop_n && !cin_n)
      p_prop_passes_carry_r5: assert (!cout_n) else $error("propagate lost carry");
  end

endmodule

bind alu4_slice alu4_slice_chk #(.W(W)) u_chk (
  .a(a), .b(b), .sel(sel), .mode(mode), .cin_n(cin_n),
  .f(f), .cout_n(cout_n), .prop_n(prop_n), .gen_n(gen_n), .eq(eq)
);

// File: tb/alu4_slice_test.sv
module alu4_slice_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [3:0] a, b, sel, f, a2, b2, f2;
  logic mode, cin_n, cout_n, prop_n, gen_n, eq;
  logic cout2_n, prop2_n, gen2_n, eq2;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  alu4_slice uut (.a(a), .b(b), .sel(sel), .mode(mode), .cin_n(cin_n),
    .f(f), .cout_n(cout_n), .prop_n(prop_n), .gen_n(gen_n), .eq(eq));
  alu4_slice hi (.a(a2), .b(b2), .sel(4'b1001), .mode(1'b0), .cin_n(cout_n),
    .f(f2), .cout_n(cout2_n), .prop_n(prop2_n), .gen_n(gen2_n), .eq(eq2));

  function automatic logic [3:0] ref_logic(logic [3:0] x, logic [3:0] y, logic [3:0] s);
    case (s)
      4'h0: return ~x;        4'h1: return ~(x | y);
      4'h2: return ~x & y;    4'h3: return 4'h0;
      4'h4: return ~(x & y);  4'h5: return ~y;
      4'h6: return x ^ y;     4'h7: return x & ~y;
      4'h8: return ~x | y;    4'h9: return ~(x ^ y);
      4'hA: return y;         4'hB: return x & y;
      4'hC: return 4'hF;      4'hD: return x | ~y;
      4'hE: return x | y;     default: return x;
    endcase
  endfunction

  function automatic logic [4:0] ref_arith(logic [3:0] x, logic [3:0] y, logic [3:0] s);
    logic [4:0] xa, xb;
    xa = {1'b0, x};
    xb = {1'b0, y};
    case (s)
      4'h0: return xa;
      4'h1: return xa | xb;
      4'h2: return {1'b0, x | ~y};
      4'h3: return 5'd15;
      4'h4: return xa + {1'b0, x & ~y};
      4'h5: return (xa | xb) + {1'b0, x & ~y};
      4'h6: return xa + {1'b0, ~y};
      4'h7: return {1'b0, x & ~y} + 5'd15;
      4'h8: return xa + (xa & xb);
      4'h9: return xa + xb;
      4'hA: return {1'b0, x | ~y} + (xa & xb);
      4'hB: return (xa & xb) + 5'd15;
      4'hC: return xa + xa;
      4'hD: return (xa | xb) + xa;
      4'hE: return {1'b0, x | ~y} + xa;
      default: return xa + 5'd15;
    endcase
  endfunction

  function automatic logic [3:0] ref_x(logic [3:0] x, logic [3:0] y, logic [1:0] s);
    case (s)
      2'd0: return x;
      2'd1: return x | y;
      2'd2: return x | ~y;
      default: return 4'hF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h sel=%h mode=%b cin_n=%b act=%h exp=%h",
               req, a, b, sel, mode, cin_n, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WDOG);
      finish_run();
    end
  end

  task automatic cascade(input logic [7:0] x, input logic [7:0] y, input logic ci_n);
    logic [8:0] sum;
    a = x[3:0]; b = y[3:0]; a2 = x[7:4]; b2 = y[7:4];
    sel = 4'b1001; mode = 1'b0; cin_n = ci_n;
    #(CLK_P/2);
    sum = {1'b0, x} + {1'b0, y} + {8'd0, ~ci_n};
    chk("R9 cascade", {~cout2_n, f2, f}, sum);
  endtask

  initial begin
    logic [4:0] r;
    void'($urandom(32'd2024));
    a = 0; b = 0; a2 = 0; b2 = 0; sel = 0; mode = 1; cin_n = 1;
    #(CLK_P/2);
    chk("R1 initial ~A", {5'd0, f}, 9'h00F);

    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 16; s++)
          for (int ia = 0; ia < 16; ia++)
            for (int ib = 0; ib < 16; ib++) begin
              a = 4'(ia); b = 4'(ib); sel = 4'(s); mode = m[0]; cin_n = c[0];
              #(CLK_P/2);
              r = ref_arith(a, b, sel);
              if (mode) begin
                chk(cin_n ? "R1 logic" : "R10 logic carry ignored",
                    {5'd0, f}, {5'd0, ref_logic(a, b, sel)});
              end else begin
                r = r + {4'd0, ~cin_n};
                chk(cin_n ? "R2 arith" : "R3 arith plus one", {5'd0, f}, {5'd0, r[3:0]});
                chk("R4 carry out", {8'd0, cout_n}, {8'd0, ~r[4]});
                if (sel == 4'b0110) begin
                  chk("R8 magnitude", {8'd0, cout_n},
                      {8'd0, ~(cin_n ? (a > b) : (a >= b))});
                  if (cin_n) chk("R7 equality", {8'd0, eq}, {8'd0, a == b});
                end
              end
              r = ref_arith(a, b, sel);
              chk("R6 group generate", {8'd0, gen_n}, {8'd0, ~r[4]});
              chk("R5 group propagate", {8'd0, prop_n},
                  {8'd0, ref_x(a, b, sel[1:0]) != 4'hF});
            end

    cascade(8'hFF, 8'h01, 1'b1);
    cascade(8'h0F, 8'h01, 1'b1);
    cascade(8'hFF, 8'h00, 1'b0);
    cascade(8'h80, 8'h80, 1'b1);
    for (int k = 0; k < 300; k++)
      cascade(8'($urandom), 8'($urandom), 1'($urandom));

    finish_run();
  end
endmodule